// File: doc/BRIEF.md
# Segment Lookaside Buffer

This block keeps a small, fully associative table of segment translations. Each slot holds two 64-bit words. The first is a segment-identifier word: the effective segment number in its upper bits, plus a valid flag. The second is a descriptor word: a segment-size field, a class bit, a page-size code and free payload. A combinational lookup port compares every slot against an effective address. Each slot matches at either 256 MB or 1 TB granularity, as its own size field selects. The port returns the lowest-numbered hitting slot and its descriptor.

A single operation port, qualified by a one-cycle strobe, maintains the table. Its operations are a validated write into a numbered slot, an indexed read of either word, a search that returns the descriptor, an invalidate of the one entry matching an address (local or global flavour), and an invalidate-all steered by a 3-bit hint. Results are registered. The block raises an error pulse for an illegal operation, and raises local or global flush-request pulses that tell the surrounding translation caches to drop stale state.

Top module: `seg_lookaside`

## Requirements
- R1: A slot hits an address A when one of two conditions holds. First: its identifier word equals A[63:28] followed by a 1 at bit 27 and zeros below, and its descriptor size field (bits 63:62) is 00 (256 MB). Second: its identifier word equals A[63:40] followed by zeros at bits 39:28, a 1 at bit 27 and zeros below, and its size field is 01 (1 TB).
- R2: When several slots hit, the lookup port reports the lowest slot index. On a miss the hit flag is low.
- R3: For a write, the slot is op_a[11:0], the identifier word is op_a[63:12] followed by 12 zeros, and the descriptor is op_b. The write raises the error pulse in any of these cases: the slot is not below ENTRIES; any of op_a[26:12] is set; the size field is 10 or 11; the size field is 01 while en_1t_i is low; the page code op_b[6:4] is not in PAGE_CODES (by default 0, 1 or 5).
- R4: A rejected write changes no slot. An accepted write is visible on the lookup and read paths from the cycle after the strobe.
- R5: Op codes 2 and 3 return the identifier word or the descriptor of slot op_a[11:0], with rd_valid_o high. A slot at or beyond ENTRIES gives the error pulse and no rd_valid_o.
- R6: A search (op code 4) matches op_a after zeroing its upper 32 bits when mode32_i is high. It returns the hitting slot's descriptor, or all ones on a miss, with rd_valid_o high.
- R7: A single invalidate (op code 5 local, 6 global) of a hitting address clears bit 27 of the lowest hitting slot. It pulses flush_local_o for code 5 and flush_global_o for code 6. On a miss it changes nothing and raises no flush.
- R8: Invalidate-all (op code 7) always pulses flush_local_o. Hints 0, 1, 2, 5 and 6 clear the valid bit of every slot except slot 0.
- R9: Hint 4 clears the valid bit of every slot, slot 0 included. Hint 3 does the same but keeps every slot whose class bit (descriptor bit 7) is 0.
- R10: Hint 7 clears no slot and only requests the local flush.
- R11: Op codes are 0 idle, 1 write, 2 read identifier, 3 read descriptor, 4 search, 5 local invalidate, 6 global invalidate, 7 invalidate-all. Every result and pulse appears in the cycle after the strobe, for one cycle only. After reset all words are zero and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_1t_i | input | 1 | Permits 1 TB segments on write |
| mode32_i | input | 1 | Core in 32-bit mode (affects search) |
| lk_addr_i | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | IDXW | Index of the hitting slot |
| lk_desc_o | output | 64 | Descriptor of the hitting slot (zero on miss) |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 3 | Operation code |
| op_a_i | input | 64 | Slot/identifier operand or address |
| op_b_i | input | 64 | Descriptor operand for writes |
| op_hint_i | input | 3 | Invalidate-all hint |
| rd_valid_o | output | 1 | Read/search result valid |
| rd_data_o | output | 64 | Read/search result |
| err_o | output | 1 | Illegal operation pulse |
| flush_local_o | output | 1 | Local flush request pulse |
| flush_global_o | output | 1 | Global flush request pulse |

## Verification
The hardest states to reach are the interactions between invalidate-all hints and per-slot attributes. Slot 0 has to be valid, and both class values have to be present on both segment sizes, at the moment each of the eight hints is applied. The stimulus refills the whole table before every hint, with the size alternating on the slot index and the class bit following index bit 1. It then reads back every identifier word to see which valid bits survived. Shadowed duplicate entries are built by writing a second slot with the same identifier. A single invalidate then peels them off one at a time.

// File: rtl/slb_pkg.sv
`timescale 1ns/1ps
package slb_pkg;
    localparam int WORD_W     = 64;
    localparam int SLOT_W     = 12;
    localparam int VALID_BIT  = 27;
    localparam int SEG256_LSB = 28;
    localparam int SEG1T_LSB  = 40;
    localparam int RSV_LSB    = 12;
    localparam int RSV_MSB    = 26;
    localparam int SIZE_LSB   = 62;
    localparam int CLASS_BIT  = 7;
    localparam int PG_LSB     = 4;
    localparam int PG_W       = 3;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_RD_ID   = 3'd2,
        OP_RD_DESC = 3'd3,
        OP_SEARCH  = 3'd4,
        OP_INV_LOC = 3'd5,
        OP_INV_GLB = 3'd6,
        OP_INV_ALL = 3'd7
    } slb_op_e;
endpackage

// File: rtl/slb_match.sv
`timescale 1ns/1ps
module slb_match
    import slb_pkg::*;
#(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input  logic [N-1:0][WORD_W-1:0] id_i,
    input  logic [N-1:0][WORD_W-1:0] desc_i,
    input  logic [WORD_W-1:0]        addr_i,
    output logic                     hit_o,
    output logic [IDXW-1:0]          idx_o,
    output logic [WORD_W-1:0]        desc_o
);
    logic [WORD_W-1:0] key_small;
    logic [WORD_W-1:0] key_large;
    logic [N-1:0]      match;

    // Keys carry the valid flag so invalid slots never compare equal.
    assign key_small = {addr_i[WORD_W-1:SEG256_LSB], 1'b1, {VALID_BIT{1'b0}}};
    assign key_large = {addr_i[WORD_W-1:SEG1T_LSB], {(SEG1T_LSB-SEG256_LSB){1'b0}},
                        1'b1, {VALID_BIT{1'b0}}};

    for (genvar n = 0; n < N; n++) begin : g_cmp
        logic [1:0] size_fld;
        assign size_fld = desc_i[n][WORD_W-1:SIZE_LSB];
        assign match[n] = ((id_i[n] == key_small) && (size_fld == SZ_256M)) ||
                          ((id_i[n] == key_large) && (size_fld == SZ_1T));
    end

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        desc_o = '0;
        for (int n = N - 1; n >= 0; n--) begin
            if (match[n]) begin
                hit_o  = 1'b1;
                idx_o  = IDXW'(n);
                desc_o = desc_i[n];
            end
        end
    end
endmodule

// File: rtl/slb_wr_check.sv
`timescale 1ns/1ps
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int              N          = 32,
    parameter int              PG_N       = 3,
    parameter logic [PG_N*3-1:0] PAGE_CODES = 9'b101_001_000
) (
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] desc_i,
    input  logic              en_1t_i,
    output logic              ok_o
);
    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(N);

    logic [PG_N-1:0] pg_hit;
    logic [1:0]      size_fld;
    logic            slot_bad;
    logic            rsv_bad;
    logic            size_bad;
    logic            large_bad;
    logic            pg_bad;

    for (genvar g = 0; g < PG_N; g++) begin : g_pg
        assign pg_hit[g] = (desc_i[PG_LSB +: PG_W] == PAGE_CODES[g*PG_W +: PG_W]);
    end

    assign size_fld  = desc_i[WORD_W-1:SIZE_LSB];
    assign slot_bad  = (opa_i[SLOT_W-1:0] >= SLOT_LIMIT);
    assign rsv_bad   = |opa_i[RSV_MSB:RSV_LSB];
    assign size_bad  = size_fld[1];
    assign large_bad = (size_fld == SZ_1T) && !en_1t_i;
    assign pg_bad    = ~|pg_hit;
    assign ok_o      = !(slot_bad || rsv_bad || size_bad || large_bad || pg_bad);
endmodule

// File: rtl/slb_purge.sv
`timescale 1ns/1ps
module slb_purge
    import slb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0][WORD_W-1:0] id_i,
    input  logic [N-1:0][WORD_W-1:0] desc_i,
    input  logic [2:0]               hint_i,
    output logic [N-1:0]             clear_o
);
    logic spare_slot0;
    logic clear_none;
    logic keep_class0;

    assign spare_slot0 = !((hint_i == 3'd3) || (hint_i == 3'd4));
    assign clear_none  = (hint_i == 3'd7);
    assign keep_class0 = (hint_i == 3'd3);

    for (genvar n = 0; n < N; n++) begin : g_ent
        localparam bit IS_FIRST = (n == 0);
        assign clear_o[n] = id_i[n][VALID_BIT] && !clear_none &&
                            !(IS_FIRST && spare_slot0) &&
                            !(keep_class0 && !desc_i[n][CLASS_BIT]);
    end
endmodule

// File: rtl/seg_lookaside.sv
`timescale 1ns/1ps
module seg_lookaside
    import slb_pkg::*;
#(
    parameter int                ENTRIES    = 32,
    parameter int                PG_N       = 3,
    parameter logic [PG_N*3-1:0] PAGE_CODES = 9'b101_001_000,
    localparam int               IDXW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_1t_i,
    input  logic              mode32_i,
    input  logic [63:0]       lk_addr_i,
    output logic              lk_hit_o,
    output logic [IDXW-1:0]   lk_slot_o,
    output logic [63:0]       lk_desc_o,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [63:0]       op_a_i,
    input  logic [63:0]       op_b_i,
    input  logic [2:0]        op_hint_i,
    output logic              rd_valid_o,
    output logic [63:0]       rd_data_o,
    output logic              err_o,
    output logic              flush_local_o,
    output logic              flush_global_o
);
    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][WORD_W-1:0] id;
        logic [ENTRIES-1:0][WORD_W-1:0] desc;
        logic [WORD_W-1:0]              rdata;
        logic                           rvalid;
        logic                           err;
        logic                           fl_loc;
        logic                           fl_glb;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0]  op_addr;
    logic               op_hit;
    logic [IDXW-1:0]    op_idx;
    logic [WORD_W-1:0]  op_desc;
    logic               wr_ok;
    logic [ENTRIES-1:0] purge;
    logic [SLOT_W-1:0]  op_slot;
    logic               slot_in_range;

    assign op_slot       = op_a_i[SLOT_W-1:0];
    assign slot_in_range = (op_slot < SLOT_LIMIT);
    assign op_addr = ((op_code_i == OP_SEARCH) && mode32_i) ?
                     {32'b0, op_a_i[31:0]} : op_a_i;

    slb_match #(.N(ENTRIES), .IDXW(IDXW)) u_lk_match (
        .id_i   (st_q.id),
        .desc_i (st_q.desc),
        .addr_i (lk_addr_i),
        .hit_o  (lk_hit_o),
        .idx_o  (lk_slot_o),
        .desc_o (lk_desc_o)
    );

    slb_match #(.N(ENTRIES), .IDXW(IDXW)) u_op_match (
        .id_i   (st_q.id),
        .desc_i (st_q.desc),
        .addr_i (op_addr),
        .hit_o  (op_hit),
        .idx_o  (op_idx),
        .desc_o (op_desc)
    );

    slb_wr_check #(.N(ENTRIES), .PG_N(PG_N), .PAGE_CODES(PAGE_CODES)) u_wr_check (
        .opa_i   (op_a_i),
        .desc_i  (op_b_i),
        .en_1t_i (en_1t_i),
        .ok_o    (wr_ok)
    );

    slb_purge #(.N(ENTRIES)) u_purge (
        .id_i    (st_q.id),
        .desc_i  (st_q.desc),
        .hint_i  (op_hint_i),
        .clear_o (purge)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.err    = 1'b0;
        st_d.fl_loc = 1'b0;
        st_d.fl_glb = 1'b0;
        if (op_valid_i) begin
            case (op_code_i)
                OP_WRITE: begin
                    if (wr_ok) begin
                        st_d.id[op_slot[IDXW-1:0]]   = {op_a_i[WORD_W-1:SLOT_W], {SLOT_W{1'b0}}};
                        st_d.desc[op_slot[IDXW-1:0]] = op_b_i;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_RD_ID, OP_RD_DESC: begin
                    if (slot_in_range) begin
                        st_d.rvalid = 1'b1;
                        st_d.rdata  = (op_code_i == OP_RD_ID) ?
                                      st_q.id[op_slot[IDXW-1:0]] :
                                      st_q.desc[op_slot[IDXW-1:0]];
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_SEARCH: begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = op_hit ? op_desc : {WORD_W{1'b1}};
                end
                OP_INV_LOC, OP_INV_GLB: begin
                    if (op_hit) begin
                        st_d.id[op_idx][VALID_BIT] = 1'b0;
                        st_d.fl_loc = (op_code_i == OP_INV_LOC);
                        st_d.fl_glb = (op_code_i == OP_INV_GLB);
                    end
                end
                OP_INV_ALL: begin
                    st_d.fl_loc = 1'b1;
                    for (int n = 0; n < ENTRIES; n++) begin
                        if (purge[n]) st_d.id[n][VALID_BIT] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o     = st_q.rvalid;
    assign rd_data_o      = st_q.rdata;
    assign err_o          = st_q.err;
    assign flush_local_o  = st_q.fl_loc;
    assign flush_global_o = st_q.fl_glb;

    // A reported hit always comes from a slot with a legal size field.
    assert_hit_size_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> !lk_desc_o[63]);

    assert_bad_write_errs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_WRITE && !wr_ok) |=> err_o);

    assert_bad_write_keeps_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_WRITE && !wr_ok) |=>
        (st_q.id == $past(st_q.id)) && (st_q.desc == $past(st_q.desc)));

    assert_oob_read_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_code_i == OP_RD_ID || op_code_i == OP_RD_DESC) && !slot_in_range)
        |=> err_o && !rd_valid_o);

    assert_global_inv_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_INV_GLB && op_hit) |=> flush_global_o && !flush_local_o);

    assert_inv_all_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_INV_ALL) |=> flush_local_o && !flush_global_o);

    assert_hint7_keeps_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_INV_ALL && op_hint_i == 3'd7) |=>
        $stable(st_q.id));
endmodule

// File: tb/seg_lookaside_test.sv
`timescale 1ns/1ps
module seg_lookaside_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_1t = 1'b1;
    logic        mode32 = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [4:0]  lk_slot;
    logic [63:0] lk_desc;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [2:0]  op_hint = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        err;
    logic        fl_loc;
    logic        fl_glb;

    seg_lookaside #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .en_1t_i(en_1t), .mode32_i(mode32),
        .lk_addr_i(lk_addr), .lk_hit_o(lk_hit), .lk_slot_o(lk_slot), .lk_desc_o(lk_desc),
        .op_valid_i(op_valid), .op_code_i(op_code), .op_a_i(op_a), .op_b_i(op_b),
        .op_hint_i(op_hint), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err),
        .flush_local_o(fl_loc), .flush_global_o(fl_glb)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [63:0] m_id [N];
    logic [63:0] m_desc [N];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_find(input logic [63:0] a);
        for (int n = 0; n < N; n++) begin
            if ((m_id[n] == {a[63:28], 1'b1, 27'b0} && m_desc[n][63:62] == 2'b00) ||
                (m_id[n] == {a[63:40], 12'b0, 1'b1, 27'b0} && m_desc[n][63:62] == 2'b01))
                return n;
        end
        return -1;
    endfunction

    task automatic do_op(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] h);
        op_valid = 1'b1; op_code = c; op_a = a; op_b = b; op_hint = h;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic probe(input logic [63:0] a, input string req);
        int e;
        lk_addr = a;
        #1;
        e = ref_find(a);
        chk(lk_hit == (e >= 0), req, 64'(lk_hit), 64'(e >= 0));
        if (e >= 0) begin
            chk(32'(lk_slot) == e, req, 64'(lk_slot), 64'(e));
            chk(lk_desc == m_desc[e], req, lk_desc, m_desc[e]);
        end
    endtask

    function automatic logic [63:0] mk_id(input int n);
        if (n % 2 == 0) return {36'(n), 1'b1, 27'b0};
        return {24'(256 + n), 12'b0, 1'b1, 27'b0};
    endfunction

    function automatic logic [63:0] mk_desc(input int n);
        logic [1:0] sz;
        sz = (n % 2 == 0) ? 2'b00 : 2'b01;
        return {sz, 14'(n), 40'b0, n[1], (n % 3 == 0) ? 3'd5 : 3'd0, 4'b0};
    endfunction

    task automatic fill();
        en_1t = 1'b1;
        for (int n = 0; n < N; n++) begin
            do_op(3'd1, mk_id(n) | 64'(n), mk_desc(n), 3'd0);
            chk(err == 1'b0, "R4 fill write accepted", 64'(err), 64'd0);
            m_id[n] = mk_id(n);
            m_desc[n] = mk_desc(n);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < N; n++) begin m_id[n] = '0; m_desc[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(!err && !fl_loc && !fl_glb && !rd_valid, "R11 reset pulses low",
            {60'b0, err, fl_loc, fl_glb, rd_valid}, 64'd0);
        probe(64'h0, "R11 reset lookup misses");
        do_op(3'd3, 64'd0, 64'd0, 3'd0);
        chk(rd_valid && rd_data == 64'd0, "R11 reset slot zero", rd_data, 64'd0);

        // R3/R4 write validation sweep
        for (int s = 0; s < 4; s++)
        for (int r = 0; r < 2; r++)
        for (int sz = 0; sz < 4; sz++)
        for (int en = 0; en < 2; en++)
        for (int pg = 0; pg < 8; pg++) begin
            logic [11:0] slot;
            logic [63:0] a, d, idw;
            bit exp_err;
            slot = (s == 0) ? 12'd3 : (s == 1) ? 12'd31 : (s == 2) ? 12'd32 : 12'd4095;
            idw = {36'h000000ABC, 1'b1, (r != 0) ? 15'h0100 : 15'h0, 12'b0};
            a = idw | 64'(slot);
            d = {2'(sz), 14'h155, 40'b0, 1'b0, 3'(pg), 4'b0};
            exp_err = (slot >= 12'(N)) || (r != 0) || (sz >= 2) || (sz == 1 && en == 0) ||
                      !(pg == 0 || pg == 1 || pg == 5);
            en_1t = en[0];
            do_op(3'd1, a, d, 3'd0);
            chk(err == exp_err, "R3 write error flag", 64'(err), 64'(exp_err));
            if (!exp_err) begin m_id[slot[4:0]] = idw; m_desc[slot[4:0]] = d; end
            if (slot < 12'(N)) begin
                do_op(3'd3, 64'(slot), 64'd0, 3'd0);
                chk(rd_data == m_desc[slot[4:0]], "R4 table after write", rd_data, m_desc[slot[4:0]]);
            end
        end

        // R1 lookup sweep over a full table
        fill();
        for (int n = 0; n < N; n++) begin
            if (n % 2 == 0) begin
                probe({36'(n), 28'h0000000}, "R1 256MB low");
                probe({36'(n), 28'hFFFFFFF}, "R1 256MB high");
                probe({36'(n), 28'h5A5A5A5}, "R1 256MB mid");
            end else begin
                probe({24'(256 + n), 40'h0}, "R1 1TB low");
                probe({24'(256 + n), 40'hFFFFFFFFFF}, "R1 1TB high");
                probe({24'(256 + n), 40'h3C3C3C3C3C}, "R1 1TB mid");
            end
        end
        for (int n = 33; n < 41; n++) probe({36'(n), 28'h1234567}, "R1 miss");

        // R5 indexed reads
        for (int n = 0; n < N; n++) begin
            do_op(3'd2, 64'(n), 64'd0, 3'd0);
            chk(rd_valid && rd_data == m_id[n], "R5 read id", rd_data, m_id[n]);
            do_op(3'd3, 64'(n), 64'd0, 3'd0);
            chk(rd_valid && rd_data == m_desc[n], "R5 read desc", rd_data, m_desc[n]);
        end
        do_op(3'd2, 64'd32, 64'd0, 3'd0);
        chk(err && !rd_valid, "R5 oob read id", {62'b0, err, rd_valid}, 64'd2);
        do_op(3'd3, 64'hFFF, 64'd0, 3'd0);
        chk(err && !rd_valid, "R5 oob read desc", {62'b0, err, rd_valid}, 64'd2);
        @(negedge clk);
        chk(!err, "R11 error lasts one cycle", 64'(err), 64'd0);

        // R6 search
        for (int n = 0; n < 16; n += 2) begin
            logic [63:0] sa;
            sa = {32'hDEADBEEF, 4'(n), 28'h1234567};
            mode32 = 1'b1;
            do_op(3'd4, sa, 64'd0, 3'd0);
            chk(rd_valid && rd_data == m_desc[n], "R6 search 32-bit hit", rd_data, m_desc[n]);
            mode32 = 1'b0;
            do_op(3'd4, sa, 64'd0, 3'd0);
            chk(rd_valid && rd_data == '1, "R6 search 64-bit miss", rd_data, '1);
        end
        do_op(3'd4, {24'(256 + 7), 40'h77}, 64'd0, 3'd0);
        chk(rd_data == m_desc[7], "R6 search 1TB", rd_data, m_desc[7]);

        // R2 priority and R7 single invalidate
        do_op(3'd1, mk_id(4) | 64'd20, {2'b00, 14'h3FFF, 40'b0, 1'b1, 3'd1, 4'b0}, 3'd0);
        m_id[20] = mk_id(4);
        m_desc[20] = {2'b00, 14'h3FFF, 40'b0, 1'b1, 3'd1, 4'b0};
        probe({36'd4, 28'h0ABCDEF}, "R2 lowest slot wins");
        do_op(3'd5, {36'd4, 28'h0ABCDEF}, 64'd0, 3'd0);
        chk(fl_loc && !fl_glb, "R7 local flush", {62'b0, fl_loc, fl_glb}, 64'd2);
        m_id[4][27] = 1'b0;
        probe({36'd4, 28'h0ABCDEF}, "R7 next duplicate exposed");
        do_op(3'd6, {36'd4, 28'h0000001}, 64'd0, 3'd0);
        chk(fl_glb && !fl_loc, "R7 global flush", {62'b0, fl_loc, fl_glb}, 64'd1);
        m_id[20][27] = 1'b0;
        probe({36'd4, 28'h0000001}, "R7 all duplicates gone");
        do_op(3'd6, {36'd4, 28'h0000001}, 64'd0, 3'd0);
        chk(!fl_glb && !fl_loc, "R7 miss no flush", {62'b0, fl_loc, fl_glb}, 64'd0);

        // R8/R9/R10 invalidate-all per hint
        for (int h = 0; h < 8; h++) begin
            fill();
            do_op(3'd7, 64'd0, 64'd0, 3'(h));
            chk(fl_loc && !fl_glb, "R8 inv-all local flush", {62'b0, fl_loc, fl_glb}, 64'd2);
            for (int n = 0; n < N; n++) begin
                bit clr;
                clr = (h != 7) && (n != 0 || h == 3 || h == 4) && !(h == 3 && mk_desc(n)[7] == 1'b0);
                if (clr) m_id[n][27] = 1'b0;
                do_op(3'd2, 64'(n), 64'd0, 3'd0);
                if (h == 7)
                    chk(rd_data == m_id[n], "R10 hint 7 keeps slot", rd_data, m_id[n]);
                else if (h == 3 || h == 4)
                    chk(rd_data == m_id[n], "R9 hint slot valid", rd_data, m_id[n]);
                else
                    chk(rd_data == m_id[n], "R8 hint slot valid", rd_data, m_id[n]);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule